// File: doc/BRIEF.md
# Queue Status and Interrupt Aggregator

This block collects condition flags and event pulses from two groups of hardware queues (queue storage lives elsewhere) and presents them as a word-addressed register window. It also drives one interrupt line per group. The two groups are deliberately unequal.

The lower group has 32 queues. Each has a live 4-bit condition field, two sticky event bits (underflow and overflow), and a programmable interrupt source chosen from eight conditions. The upper group has 32 queues with only a nearly-empty bitmap and a full bitmap. Its interrupt source is always nearly-empty.

Each queue has an interrupt flag bit and an enable bit. A group's interrupt line is asserted when any of that group's flags is set together with its enable. The flags work in one of two modes, selected by one global control bit:
- Level mode: a flag follows its chosen condition.
- Sticky mode: a flag latches on a rising edge of its condition and stays set until software clears it.

The register port is a plain single-cycle strobe. Reads are combinational, and a write takes effect at the next clock edge. There is no back-pressure anywhere: every access completes in the cycle it is presented.

Top module: `qstat_irq_agg`

## Requirements
- R1: Words 0 to 3 show the live lower-group conditions. Queue q sits in word q/8 at bits (q mod 8)*4 upward, with bit 0 = empty, bit 1 = nearly empty, bit 2 = nearly full and bit 3 = full. Writes to these words have no effect.
- R2: Words 4 and 5 hold sticky event bits. Queue q sits in word 4 + q/16, with underflow at bit 2*(q mod 16) and overflow at the bit above it. A pulse on `uf_evt[q]` or `of_evt[q]` sets the bit at the next edge, and the bit stays set.
- R3: Writing word 4 or 5 clears every event bit written as 0 and leaves every bit written as 1 unchanged. An event pulse in the same cycle as the clearing write wins, so the bit ends up set.
- R4: Word 6 shows `hi_ne` and word 7 shows `hi_full` live, with bit (q-32) for queue q. Writes to these words have no effect.
- R5: Words 8 to 11 are read/write source-select words. Queue q has a 4-bit field in word 8 + q/8 at bits (q mod 8)*4. The low 3 bits of the field pick its condition:
  - 0 = empty, 1 = nearly empty, 2 = nearly full, 3 = full;
  - 4 to 7 select the inverse of 0 to 3 respectively.
- R6: The interrupt condition of upper queue q is always `hi_ne[q-32]`.
- R7: When bit 3 of word 8 is 0 (level mode), each bit of flag words 14 (lower) and 15 (upper) equals its queue's selected condition as sampled at the previous edge. Writes to the flag words have no effect in this mode.
- R8: When bit 3 of word 8 is 1 (sticky mode), a flag bit is set at the edge where its selected condition is 1 and was 0 at the previous edge. The bit then holds until a write of 1 to that bit of its flag word clears it. A rising edge in the same cycle as the clear wins.
- R9: Words 12 and 13 are read/write enable words, for the lower and upper groups. `irq_lo` equals the OR of (word 14 AND word 12), and `irq_hi` equals the OR of (word 15 AND word 13).
- R10: Reset clears all stored registers: event bits, select words, enables, flags and previous-condition state. Addresses 16 to 31 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_cond | input | 128 | Lower-group live conditions, 4 bits per queue |
| uf_evt | input | 32 | Lower-group underflow event pulses |
| of_evt | input | 32 | Lower-group overflow event pulses |
| hi_ne | input | 32 | Upper-group nearly-empty levels |
| hi_full | input | 32 | Upper-group full levels |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_lo | output | 1 | Lower-group interrupt |
| irq_hi | output | 1 | Upper-group interrupt |

## Verification
The bench first uses fixed patterns to set up specific cases:
- distinct select codes per queue, so that a wrong field position or a wrong inversion shows up as a wrong flag bit;
- single-queue event pulses, including one that lands in the same cycle as a clearing write, to separate "event wins" from "write wins";
- condition toggles in sticky mode, which separate edge capture from level following and show whether a write-one clear acts on the right bits.

A long random phase then mixes:
- changing conditions;
- sparse event pulses;
- writes to every address, including read-only and unmapped ones and the mode bit.

In the random phase every readable word and both interrupt lines are compared against a behavioural model on each clock.

// File: rtl/qsa_pkg.sv
package qsa_pkg;
  localparam int WORD_W      = 32;
  localparam int GRP_Q       = 32;
  localparam int ST_BITS     = 4;
  localparam int CODE_W      = 3;
  localparam int ST_PER_WORD = WORD_W / ST_BITS;
  localparam int ST_WORDS    = GRP_Q / ST_PER_WORD;
  localparam int UO_BITS     = 2;
  localparam int UO_PER_WORD = WORD_W / UO_BITS;
  localparam int UO_WORDS    = GRP_Q / UO_PER_WORD;
  localparam int A_ST        = 0;
  localparam int A_UO        = A_ST + ST_WORDS;
  localparam int A_HNE       = A_UO + UO_WORDS;
  localparam int A_HFULL     = A_HNE + 1;
  localparam int A_SEL       = A_HFULL + 1;
  localparam int A_EN        = A_SEL + ST_WORDS;
  localparam int A_FLG       = A_EN + 2;
  localparam int MAP_WORDS   = A_FLG + 2;
  localparam int ADDR_W      = $clog2(MAP_WORDS) + 1;
  localparam int STICKY_BIT  = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_EMPTY     = 3'd0,
    SRC_NEMPTY    = 3'd1,
    SRC_NFULL     = 3'd2,
    SRC_FULL      = 3'd3,
    SRC_NOT_EMPTY = 3'd4,
    SRC_NOT_NE    = 3'd5,
    SRC_NOT_NF    = 3'd6,
    SRC_NOT_FULL  = 3'd7
  } src_e;

  // Codes 4..7 are the inverses of codes 0..3.
  function automatic logic src_pick(input logic [ST_BITS-1:0] f, input src_e code);
    logic [CODE_W-1:0] c;
    c = code;
    return f[c[1:0]] ^ c[2];
  endfunction
endpackage

// File: rtl/qsa_cond_sel.sv
module qsa_cond_sel
  import qsa_pkg::*;
#(
  parameter int NQ = GRP_Q
) (
  input  logic [NQ*ST_BITS-1:0] flags_i,
  input  logic [NQ*CODE_W-1:0]  code_i,
  output logic [NQ-1:0]         cond_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign cond_o[q] = src_pick(flags_i[q*ST_BITS +: ST_BITS], src_e'(code_i[q*CODE_W +: CODE_W]));
  end
endmodule

// File: rtl/qsa_sticky_bits.sv
module qsa_sticky_bits
  import qsa_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [GRP_Q-1:0]           uf_i,
  input  logic [GRP_Q-1:0]           of_i,
  input  logic [UO_WORDS-1:0]        wsel_i,
  input  logic [WORD_W-1:0]          wdata_i,
  output logic [UO_WORDS*WORD_W-1:0] bits_o
);
  localparam int NB = UO_WORDS * WORD_W;

  logic [NB-1:0] set_v, keep_v, bits_q;

  for (genvar q = 0; q < GRP_Q; q++) begin : g_set
    assign set_v[UO_BITS*q]     = uf_i[q];
    assign set_v[UO_BITS*q + 1] = of_i[q];
  end

  for (genvar w = 0; w < UO_WORDS; w++) begin : g_keep
    assign keep_v[w*WORD_W +: WORD_W] = wsel_i[w] ? wdata_i : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= (bits_q & keep_v) | set_v;
  end

  assign bits_o = bits_q;

  // R2: an event pulse is visible after the edge
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((bits_q & $past(set_v)) == $past(set_v)));

  // R3: without a write no event bit falls
  p_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel_i == '0) |=> ((bits_q & $past(bits_q)) == $past(bits_q)));
endmodule

// File: rtl/qsa_flag_group.sv
module qsa_flag_group #(
  parameter int NQ = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] cond_i,
  input  logic          sticky_i,
  input  logic          clr_i,
  input  logic [NQ-1:0] clr_mask_i,
  input  logic [NQ-1:0] en_i,
  output logic [NQ-1:0] flags_o,
  output logic          irq_o
);
  logic [NQ-1:0] prev_q, flag_q, rise, clr_v;

  assign rise  = cond_i & ~prev_q;
  assign clr_v = clr_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= cond_i;
      if (sticky_i) flag_q <= (flag_q & ~clr_v) | rise;
      else          flag_q <= cond_i;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);

  // R7: level mode tracks the condition one edge later
  p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_i |=> (flags_o == $past(cond_i)));

  // R8: sticky flags never drop without a clear
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_i && !clr_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R9: an interrupt needs at least one enable
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_i != '0));
endmodule

// File: rtl/qstat_irq_agg.sv
module qstat_irq_agg
  import qsa_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GRP_Q*ST_BITS-1:0]  lo_cond,
  input  logic [GRP_Q-1:0]          uf_evt,
  input  logic [GRP_Q-1:0]          of_evt,
  input  logic [GRP_Q-1:0]          hi_ne,
  input  logic [GRP_Q-1:0]          hi_full,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [WORD_W-1:0]         reg_wdata,
  output logic [WORD_W-1:0]         reg_rdata,
  output logic                      irq_lo,
  output logic                      irq_hi
);
  logic [ST_WORDS*WORD_W-1:0] sel_q;
  logic [GRP_Q-1:0]           en_lo_q, en_hi_q;
  logic [ST_WORDS-1:0]        sel_we;
  logic [UO_WORDS-1:0]        uo_we;
  logic                       en_lo_we, en_hi_we, fl_lo_we, fl_hi_we;
  logic [GRP_Q*CODE_W-1:0]    codes;
  logic [GRP_Q-1:0]           cond_lo, flags_lo, flags_hi;
  logic [UO_WORDS*WORD_W-1:0] uo_bits;
  logic                       sticky;

  // write decode
  always_comb begin
    for (int k = 0; k < ST_WORDS; k++)
      sel_we[k] = reg_we && (reg_addr == ADDR_W'(A_SEL + k));
    for (int k = 0; k < UO_WORDS; k++)
      uo_we[k] = reg_we && (reg_addr == ADDR_W'(A_UO + k));
  end
  assign en_lo_we = reg_we && (reg_addr == ADDR_W'(A_EN));
  assign en_hi_we = reg_we && (reg_addr == ADDR_W'(A_EN + 1));
  assign fl_lo_we = reg_we && (reg_addr == ADDR_W'(A_FLG));
  assign fl_hi_we = reg_we && (reg_addr == ADDR_W'(A_FLG + 1));

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      en_lo_q <= '0;
      en_hi_q <= '0;
    end else begin
      for (int k = 0; k < ST_WORDS; k++)
        if (sel_we[k]) sel_q[k*WORD_W +: WORD_W] <= reg_wdata;
      if (en_lo_we) en_lo_q <= reg_wdata[GRP_Q-1:0];
      if (en_hi_we) en_hi_q <= reg_wdata[GRP_Q-1:0];
    end
  end

  assign sticky = sel_q[STICKY_BIT];

  for (genvar q = 0; q < GRP_Q; q++) begin : g_code
    assign codes[q*CODE_W +: CODE_W] = sel_q[q*ST_BITS +: CODE_W];
  end

  qsa_cond_sel #(.NQ(GRP_Q)) u_cond (
    .flags_i (lo_cond),
    .code_i  (codes),
    .cond_o  (cond_lo)
  );

  qsa_sticky_bits u_uo (
    .clk     (clk),
    .rst_n   (rst_n),
    .uf_i    (uf_evt),
    .of_i    (of_evt),
    .wsel_i  (uo_we),
    .wdata_i (reg_wdata),
    .bits_o  (uo_bits)
  );

  qsa_flag_group #(.NQ(GRP_Q)) u_grp_lo (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond_lo),
    .sticky_i   (sticky),
    .clr_i      (fl_lo_we),
    .clr_mask_i (reg_wdata[GRP_Q-1:0]),
    .en_i       (en_lo_q),
    .flags_o    (flags_lo),
    .irq_o      (irq_lo)
  );

  // upper group source is fixed to nearly-empty
  qsa_flag_group #(.NQ(GRP_Q)) u_grp_hi (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (hi_ne),
    .sticky_i   (sticky),
    .clr_i      (fl_hi_we),
    .clr_mask_i (reg_wdata[GRP_Q-1:0]),
    .en_i       (en_hi_q),
    .flags_o    (flags_hi),
    .irq_o      (irq_hi)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < ST_WORDS; k++)
      if (reg_addr == ADDR_W'(A_ST + k)) reg_rdata = lo_cond[k*WORD_W +: WORD_W];
    for (int k = 0; k < UO_WORDS; k++)
      if (reg_addr == ADDR_W'(A_UO + k)) reg_rdata = uo_bits[k*WORD_W +: WORD_W];
    for (int k = 0; k < ST_WORDS; k++)
      if (reg_addr == ADDR_W'(A_SEL + k)) reg_rdata = sel_q[k*WORD_W +: WORD_W];
    if (reg_addr == ADDR_W'(A_HNE))     reg_rdata = hi_ne;
    if (reg_addr == ADDR_W'(A_HFULL))   reg_rdata = hi_full;
    if (reg_addr == ADDR_W'(A_EN))      reg_rdata = en_lo_q;
    if (reg_addr == ADDR_W'(A_EN + 1))  reg_rdata = en_hi_q;
    if (reg_addr == ADDR_W'(A_FLG))     reg_rdata = flags_lo;
    if (reg_addr == ADDR_W'(A_FLG + 1)) reg_rdata = flags_hi;
  end

  // R10: the unmapped range reads as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'(MAP_WORDS)) |-> (reg_rdata == '0));

  // R9: a disabled upper group never interrupts
  p_hi_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi_q == '0) |-> !irq_hi);
endmodule

// File: tb/qstat_irq_agg_tb.sv
`timescale 1ns/1ps
module qstat_irq_agg_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] lo_cond = '0;
  logic [31:0]  uf_evt = '0, of_evt = '0, hi_ne = '0, hi_full = '0;
  logic         reg_we = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qstat_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .lo_cond(lo_cond), .uf_evt(uf_evt), .of_evt(of_evt),
    .hi_ne(hi_ne), .hi_full(hi_full), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // behavioural model
  logic [31:0] m_uo [2];
  logic [31:0] m_sel [4];
  logic [31:0] m_en [2];
  logic [31:0] m_fl [2];
  logic [31:0] m_prev [2];

  function automatic logic [31:0] lo_conditions();
    logic [31:0] c;
    for (int q = 0; q < 32; q++) begin
      logic [3:0] f;
      logic [2:0] s;
      f = lo_cond[q*4 +: 4];
      s = m_sel[q/8][(q%8)*4 +: 3];
      c[q] = f[s[1:0]] ^ s[2];
    end
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_uo[i] = '0; m_en[i] = '0; m_fl[i] = '0; m_prev[i] = '0;
      end
      for (int i = 0; i < 4; i++) m_sel[i] = '0;
    end else begin
      logic [31:0] c [2];
      logic        stk;
      c[0] = lo_conditions();
      c[1] = hi_ne;
      stk  = m_sel[0][3];
      for (int g = 0; g < 2; g++) begin
        logic [31:0] clr;
        clr = (reg_we && reg_addr == 5'(14 + g)) ? reg_wdata : 32'h0;
        if (stk) m_fl[g] = (m_fl[g] & ~clr) | (c[g] & ~m_prev[g]);
        else     m_fl[g] = c[g];
        m_prev[g] = c[g];
      end
      for (int k = 0; k < 2; k++)
        if (reg_we && reg_addr == 5'(4 + k)) m_uo[k] = m_uo[k] & reg_wdata;
      for (int q = 0; q < 32; q++) begin
        if (uf_evt[q]) m_uo[q/16][2*(q%16)]     = 1'b1;
        if (of_evt[q]) m_uo[q/16][2*(q%16) + 1] = 1'b1;
      end
      for (int k = 0; k < 4; k++)
        if (reg_we && reg_addr == 5'(8 + k)) m_sel[k] = reg_wdata;
      for (int k = 0; k < 2; k++)
        if (reg_we && reg_addr == 5'(12 + k)) m_en[k] = reg_wdata;
    end
  end

  function automatic logic [31:0] exp_word(input logic [4:0] a);
    if (a < 4)        return lo_cond[a*32 +: 32];
    else if (a < 6)   return m_uo[a-4];
    else if (a == 6)  return hi_ne;
    else if (a == 7)  return hi_full;
    else if (a < 12)  return m_sel[a-8];
    else if (a < 14)  return m_en[a-12];
    else if (a < 16)  return m_fl[a-14];
    return 32'h0;
  endfunction

  function automatic string tag(input logic [4:0] a);
    if (a < 4)        return "R1";
    else if (a < 6)   return "R2/R3";
    else if (a < 8)   return "R4";
    else if (a < 12)  return "R5";
    else if (a < 14)  return "R9";
    else if (a == 14) return "R7/R8";
    else if (a == 15) return "R6/R7/R8";
    return "R10";
  endfunction

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      logic [31:0] e;
      logic        el, eh;
      e  = exp_word(reg_addr);
      el = |(m_fl[0] & m_en[0]);
      eh = |(m_fl[1] & m_en[1]);
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s addr %0d: got %h expected %h", tag(reg_addr), reg_addr, reg_rdata, e);
      end
      checks++;
      if (irq_lo !== el || irq_hi !== eh) begin
        errors++;
        $display("FAIL R9 irq lo/hi: got %b%b expected %b%b", irq_lo, irq_hi, el, eh);
      end
    end
  end

  task automatic rd(input int a);
    @(negedge clk);
    reg_we = 0; reg_addr = 5'(a);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R10: reset values and unmapped range
    for (int a = 0; a < 32; a++) rd(a);
    // R1, R4: live status words with distinct patterns, writes ignored
    lo_cond = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
    hi_ne = 32'hA5A5_0F0F; hi_full = 32'h1234_8001;
    for (int a = 0; a < 8; a++) rd(a);
    wr(1, 32'hFFFF_FFFF); wr(6, 32'h0); wr(7, 32'hFFFF_FFFF);
    // R2, R3: event capture and clearing
    @(negedge clk); uf_evt = 32'h0000_0008; of_evt = 32'h0010_0000;
    @(negedge clk); uf_evt = '0; of_evt = '0;
    rd(4); rd(5); rd(4);
    wr(4, ~32'h0000_0040);
    rd(4);
    @(negedge clk); uf_evt = 32'h0000_0008;
    reg_we = 1; reg_addr = 5'd4; reg_wdata = 32'h0;
    @(negedge clk); uf_evt = '0; reg_we = 0;
    rd(4);
    // R5, R7: select codes 0..7 on queues 0..7, level mode
    wr(8, 32'h7654_3210); wr(9, 32'h0123_4567); wr(12, 32'hFFFF_FFFF); wr(13, 32'h0000_00FF);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); lo_cond = {$urandom, $urandom, $urandom, $urandom}; hi_ne = $urandom;
      reg_addr = 5'(14 + (i % 2));
    end
    wr(14, 32'hFFFF_FFFF);
    // R8, R6: sticky mode with toggles and write-one clears
    wr(8, 32'h7654_3218);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); lo_cond = ~lo_cond; hi_ne = (i % 2) ? 32'h0 : 32'h8000_0003;
      reg_addr = 5'(14 + (i % 2));
    end
    wr(15, 32'h0000_0001); rd(15);
    wr(14, 32'h0000_FFFF); rd(14);
    wr(13, 32'h0); rd(13);
    // random phase over every address and mode
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        lo_cond = {$urandom, $urandom, $urandom, $urandom};
        hi_ne = $urandom; hi_full = $urandom;
      end
      uf_evt = $urandom & $urandom & $urandom;
      of_evt = $urandom & $urandom & $urandom;
      if ($urandom % 6 == 0) begin
        reg_we = 1; reg_addr = 5'($urandom); reg_wdata = $urandom;
      end else begin
        reg_we = 0; reg_addr = 5'(i % 32);
      end
    end
    @(negedge clk); reg_we = 0; uf_evt = '0; of_evt = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule